// File: doc/BRIEF.md
# Dual-Edge Stereo PDM Capture

This block drives the bit clock for a pair of PDM MEMS microphones that share a single data wire, and splits their interleaved output into two separate 1-bit streams. One microphone is configured as left and answers the rising clock edge. The other is configured as right and answers the falling edge. The block divides its system clock by an even integer ratio to make the microphone clock, for example 24.576 MHz divided by 8 gives 3.072 MHz. Both microphones must be clocked from this one output. The shared data line is sampled only at fixed phases of the divider, so the capture is always timed against the generated clock.

A small state machine walks through three named states: `MC_IDLE` (clock parked low), `MC_HIGH` (first half of a period, clock high) and `MC_LOW` (second half, clock low). Its transitions are named as follows:

- **start**: `MC_IDLE` to `MC_HIGH`, taken when enable is seen.
- **half**: `MC_HIGH` to `MC_LOW`, taken at the last phase of the high half.
- **wrap**: `MC_LOW` to `MC_HIGH`, taken at the last phase of the low half.
- **stop**: `MC_HIGH` or `MC_LOW` to `MC_IDLE`, taken whenever enable drops.

The left bit is taken in the last system cycle of the high half, and the right bit in the last system cycle of the low half. Each point is one system cycle before the opposite clock edge, which gives the microphone output time to settle. Once per complete period the two bits are presented together with a one-cycle valid strobe. A per-channel counter records every bit that was captured.

Top module: `pdm_stereo_capture`

## Requirements
- R1: While enabled, `mic_clk_o` has a period of DIV system cycles: DIV/2 cycles high followed by DIV/2 cycles low. It first goes high in the cycle after the clock edge that first samples `en` high.
- R2: One cycle after an edge that samples `en` low, `mic_clk_o` is 0 and `pair_valid_o` is 0, and both stay 0 while `en` remains low.
- R3: The left bit of a pair equals the value of `mic_data_i` at the clock edge that ends the high half of that microphone period (the last cycle in which `mic_clk_o` is 1).
- R4: The right bit of a pair equals the value of `mic_data_i` at the clock edge that ends the low half of that microphone period (the last cycle in which `mic_clk_o` is 0).
- R5: `pair_valid_o` is high for exactly one cycle per completed microphone period. That cycle is the first cycle of the next high half. `left_bit_o` and `right_bit_o` hold the pair until the next strobe.
- R6: `left_count_o` and `right_count_o` each increase by exactly 1 for every left or right bit captured, and wrap modulo 2^CNT_W.
- R7: A synchronous active-high `rst` clears the divider, the held bits, the valid strobe and both counters, and parks `mic_clk_o` low.
- R8: If `en` drops partway through a period, that period's pair is dropped and no strobe is issued. A left bit already captured is still counted. Re-enabling starts a fresh period at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Runs the microphone clock while high |
| mic_data_i | input | 1 | Shared PDM data wire from both microphones |
| mic_clk_o | output | 1 | Generated microphone bit clock |
| left_bit_o | output | 1 | Left (rising-edge) PDM bit of the last pair |
| right_bit_o | output | 1 | Right (falling-edge) PDM bit of the last pair |
| pair_valid_o | output | 1 | One-cycle strobe marking a new pair |
| left_count_o | output | CNT_W | Number of left bits captured |
| right_count_o | output | CNT_W | Number of right bits captured |

## Verification
A behavioural model of the two microphones drives the data wire from the left sequence while the generated clock is high, and from the right sequence while it is low.

The capture is tried with several pattern pairs, each of which exposes a different fault:
- Constant left against constant right, and the same pair swapped, show whether the channels are crossed or the sampling is on the wrong half.
- Opposite alternating sequences catch a sample taken one period early or late.
- Independent pseudo-random streams check ordering over many periods.

A disable in mid-period, followed by a re-enable, checks that the partial pair is dropped, that the counts move by exactly one left bit, and that the restart is clean. A reset after activity checks that every output clears.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    typedef enum logic [1:0] {
        MC_IDLE = 2'd0,
        MC_HIGH = 2'd1,
        MC_LOW  = 2'd2
    } mc_state_t;

    localparam int NUM_CH = 2;
    localparam int CH_L   = 0;
    localparam int CH_R   = 1;

endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen
    import pdm_cap_pkg::*;
#(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mic_clk,
    output logic cap_left,
    output logic cap_right
);
    localparam int HALF = DIV / 2;
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] LAST_HI = PH_W'(HALF - 1);
    localparam logic [PH_W-1:0] LAST    = PH_W'(DIV - 1);

    mc_state_t       state, state_n;
    logic [PH_W-1:0] ph, ph_n;
    logic            clk_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MC_IDLE;
            ph    <= '0;
            clk_q <= 1'b0;
        end else begin
            state <= state_n;
            ph    <= ph_n;
            clk_q <= (state_n == MC_HIGH);
        end
    end

    // Transitions: start, half, wrap, stop
    always_comb begin
        state_n = state;
        ph_n    = ph;
        unique case (state)
            MC_IDLE: begin
                if (en) begin
                    state_n = MC_HIGH;
                    ph_n    = '0;
                end
            end
            MC_HIGH: begin
                if (!en) begin
                    state_n = MC_IDLE;
                    ph_n    = '0;
                end else begin
                    ph_n = ph + PH_W'(1);
                    if (ph == LAST_HI) state_n = MC_LOW;
                end
            end
            MC_LOW: begin
                if (!en) begin
                    state_n = MC_IDLE;
                    ph_n    = '0;
                end else if (ph == LAST) begin
                    state_n = MC_HIGH;
                    ph_n    = '0;
                end else begin
                    ph_n = ph + PH_W'(1);
                end
            end
            default: begin
                state_n = MC_IDLE;
                ph_n    = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mic_clk   = clk_q;
        cap_left  = en && (state == MC_HIGH) && (ph == LAST_HI);
        cap_right = en && (state == MC_LOW)  && (ph == LAST);
    end

endmodule

// File: rtl/pdm_pair_sampler.sv
module pdm_pair_sampler (
    input  logic clk,
    input  logic rst,
    input  logic data_in,
    input  logic cap_left,
    input  logic cap_right,
    output logic left_bit,
    output logic right_bit,
    output logic pair_valid
);
    logic left_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold  <= 1'b0;
            left_bit   <= 1'b0;
            right_bit  <= 1'b0;
            pair_valid <= 1'b0;
        end else begin
            pair_valid <= 1'b0;
            if (cap_left) left_hold <= data_in;
            if (cap_right) begin
                left_bit   <= left_hold;
                right_bit  <= data_in;
                pair_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdm_bit_counter.sv
module pdm_bit_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)      count <= '0;
        else if (inc) count <= count + W'(1);
    end

endmodule

// File: rtl/pdm_stereo_capture.sv
module pdm_stereo_capture
    import pdm_cap_pkg::*;
#(
    parameter int DIV   = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             mic_data_i,
    output logic             mic_clk_o,
    output logic             left_bit_o,
    output logic             right_bit_o,
    output logic             pair_valid_o,
    output logic [CNT_W-1:0] left_count_o,
    output logic [CNT_W-1:0] right_count_o
);
    logic               cap_l, cap_r;
    logic [NUM_CH-1:0]  cap_vec;
    logic [CNT_W-1:0]   cnt [NUM_CH];

    pdm_clkgen #(.DIV(DIV)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mic_clk   (mic_clk_o),
        .cap_left  (cap_l),
        .cap_right (cap_r)
    );

    pdm_pair_sampler u_sampler (
        .clk        (clk),
        .rst        (rst),
        .data_in    (mic_data_i),
        .cap_left   (cap_l),
        .cap_right  (cap_r),
        .left_bit   (left_bit_o),
        .right_bit  (right_bit_o),
        .pair_valid (pair_valid_o)
    );

    assign cap_vec[CH_L] = cap_l;
    assign cap_vec[CH_R] = cap_r;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cnt
        pdm_bit_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .inc   (cap_vec[g]),
            .count (cnt[g])
        );
    end

    assign left_count_o  = cnt[CH_L];
    assign right_count_o = cnt[CH_R];

endmodule

// File: rtl/pdm_cap_checker.sv
module pdm_cap_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             mic_clk_o,
    input logic             pair_valid_o,
    input logic [CNT_W-1:0] left_count_o,
    input logic [CNT_W-1:0] right_count_o
);
    // R1: a rising microphone clock stays high for at least a second cycle while enabled
    a_r1_high_holds: assert property (@(posedge clk) disable iff (rst)
        $rose(mic_clk_o) && en |=> mic_clk_o);

    // R2: disable parks the clock and silences the strobe
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!mic_clk_o && !pair_valid_o));

    // R5: strobe is one cycle wide and lands in a high half
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |=> !pair_valid_o);
    a_r5_in_high: assert property (@(posedge clk) disable iff (rst)
        pair_valid_o |-> mic_clk_o);

    // R6: counters only ever step by one
    a_r6_left_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(left_count_o) |-> left_count_o == CNT_W'($past(left_count_o) + 1'b1));
    a_r6_right_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(right_count_o) |-> right_count_o == CNT_W'($past(right_count_o) + 1'b1));

    // R7: reset clears outputs on the next cycle
    a_r7_reset_clear: assert property (@(posedge clk)
        rst |=> (left_count_o == '0 && right_count_o == '0 && !mic_clk_o && !pair_valid_o));

endmodule

bind pdm_stereo_capture pdm_cap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .mic_clk_o     (mic_clk_o),
    .pair_valid_o  (pair_valid_o),
    .left_count_o  (left_count_o),
    .right_count_o (right_count_o)
);

// File: tb/sim_pdm_stereo_capture.sv
module sim_pdm_stereo_capture;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 8;
    localparam int HALF  = DIV / 2;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic mic_data_i = 1'b0;
    logic mic_clk_o, left_bit_o, right_bit_o, pair_valid_o;
    logic [CNT_W-1:0] left_count_o, right_count_o;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    int exp_l   = 0;
    int exp_r   = 0;
    int rises   = 0;
    logic prev_mc = 1'b0;
    logic [63:0] lpat, rpat;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_stereo_capture #(.DIV(DIV), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .en(en), .mic_data_i(mic_data_i),
        .mic_clk_o(mic_clk_o), .left_bit_o(left_bit_o), .right_bit_o(right_bit_o),
        .pair_valid_o(pair_valid_o), .left_count_o(left_count_o),
        .right_count_o(right_count_o)
    );

    // Microphone model: left talks while the clock is high, right while low
    always @(negedge clk) begin
        int idx;
        if (mic_clk_o && !prev_mc) rises++;
        prev_mc = mic_clk_o;
        idx = (rises > 0) ? (rises - 1) % 64 : 0;
        mic_data_i <= mic_clk_o ? lpat[idx] : rpat[idx];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic load_pattern(input int mode);
        logic [15:0] x;
        x = 16'hACE1;
        for (int i = 0; i < 64; i++) begin
            unique case (mode)
                0: begin lpat[i] = 1'b0; rpat[i] = 1'b1; end
                1: begin lpat[i] = 1'b1; rpat[i] = 1'b0; end
                2: begin lpat[i] = i[0]; rpat[i] = ~i[0]; end
                default: begin
                    x = {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
                    lpat[i] = x[0];
                    rpat[i] = x[7];
                end
            endcase
        end
    endtask

    // R1, R3, R4, R5, R2, R6: run whole periods, then stop on a period boundary
    task automatic run_pattern(input int mode, input int npairs);
        int t;
        int got;
        int idx;
        load_pattern(mode);
        @(negedge clk);
        rises = 0;
        en = 1'b1;
        t = 0;
        got = 0;
        while (got < npairs) begin
            @(negedge clk);
            t++;
            check("R1 mic_clk shape", int'(mic_clk_o), int'(((t-1) % DIV) < HALF));
            if (((t-1) % DIV) == 0 && t > 1) begin
                idx = (t-1) / DIV - 1;
                check("R5 valid strobe", int'(pair_valid_o), 1);
                check("R3 left bit", int'(left_bit_o), int'(lpat[idx]));
                check("R4 right bit", int'(right_bit_o), int'(rpat[idx]));
                got++;
            end else begin
                check("R5 valid idle", int'(pair_valid_o), 0);
            end
        end
        en = 1'b0;
        exp_l += npairs;
        exp_r += npairs;
        for (int k = 0; k < DIV + 2; k++) begin
            @(negedge clk);
            check("R2 clk parked", int'(mic_clk_o), 0);
            check("R2 no valid", int'(pair_valid_o), 0);
        end
        check("R6 left count", int'(left_count_o), exp_l);
        check("R6 right count", int'(right_count_o), exp_r);
    endtask

    // R8: stop inside the low half, after the left capture
    task automatic mid_disable();
        load_pattern(2);
        @(negedge clk);
        rises = 0;
        en = 1'b1;
        for (int t = 1; t <= HALF + 2; t++) @(negedge clk);
        en = 1'b0;
        exp_l += 1;
        for (int k = 0; k < DIV + 2; k++) begin
            @(negedge clk);
            check("R8 no partial pair", int'(pair_valid_o), 0);
            check("R8 clk parked", int'(mic_clk_o), 0);
        end
        check("R8 left counted", int'(left_count_o), exp_l);
        check("R8 right not counted", int'(right_count_o), exp_r);
    endtask

    // R7: reset after activity
    task automatic reset_check();
        @(negedge clk);
        en = 1'b1;
        for (int k = 0; k < 5; k++) @(negedge clk);
        rst = 1'b1;
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_l = 0;
        exp_r = 0;
        check("R7 clk low", int'(mic_clk_o), 0);
        check("R7 valid low", int'(pair_valid_o), 0);
        check("R7 left count", int'(left_count_o), 0);
        check("R7 right count", int'(right_count_o), 0);
        check("R7 left bit", int'(left_bit_o), 0);
        check("R7 right bit", int'(right_bit_o), 0);
    endtask

    initial begin
        lpat = '0;
        rpat = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R7 reset clk", int'(mic_clk_o), 0);
        check("R7 reset valid", int'(pair_valid_o), 0);
        check("R7 reset counts", int'(left_count_o) + int'(right_count_o), 0);
        run_pattern(0, 6);
        run_pattern(1, 6);
        run_pattern(2, 10);
        run_pattern(3, 40);
        mid_disable();
        run_pattern(3, 5);
        reset_check();
        run_pattern(2, 4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule